// File: doc/BRIEF.md
# Arithmetic Error Trap Detector

This block sits beside a 40-bit datapath with two accumulators, a divider and a shifter. It does not compute results. Each completed operation is presented to it as one beat of an input stream. The beat carries the selected accumulator, the 40-bit result before saturation, the signs of the two operands, a divide-start flag with its divisor, and a shift flag with its signed shift amount. The block decides whether that operation is an arithmetic error. For each cause it sets a sticky status flag, and it raises a one-cycle trap request when at least one cause is newly flagged.

There are five causes, each with its own status bit:

| Bit | Cause |
|-----|-------|
| 0 | Accumulator A overflow out of bit 31 |
| 1 | Accumulator B overflow out of bit 31 |
| 2 | Catastrophic overflow out of bit 39 |
| 3 | Divide by zero |
| 4 | Shift amount out of range |

The two accumulator overflow causes and the catastrophic cause each have an enable. They are also qualified by the guard-bit and saturation configuration. Divide by zero and an out-of-range shift are always trapped. A divide by zero also produces a divide-abort pulse, which the divider uses to stop at the next cycle boundary.

The input stream follows valid/ready rules. A beat is consumed on every clock edge where `op_valid` is high. `op_ready` is always high, because the block never applies back-pressure; the upstream may therefore present a new beat every cycle. Configuration and clear inputs are plain levels sampled on every edge.

Top module: `math_trap_detector`

## Requirements
- R1: A beat with `op_arith`=1 and `op_acc_sel`=0 whose result bits 39..31 are not all equal sets status bit 0, provided `cfg_ovf_a_en`=1 and `cfg_guard_used`=0.
- R2: The same overflow test with `op_acc_sel`=1 sets status bit 1, provided `cfg_ovf_b_en`=1 and `cfg_guard_used`=0. The enable of the accumulator that is not selected has no effect.
- R3: While `cfg_guard_used`=1, no overflow out of bit 31 sets bit 0 or bit 1.
- R4: A beat with `op_arith`=1, `op_sign_x` equal to `op_sign_y`, and result bit 39 different from them sets status bit 2. This happens only when both `cfg_cat_en`=1 and `cfg_sat_off`=1.
- R5: A beat with `op_div`=1 and `op_divisor`=0 sets status bit 3 and drives `div_abort` high for exactly the following cycle. A nonzero divisor has no effect.
- R6: A beat with `op_shift`=1 whose 6-bit two's-complement `op_shamt` is above +16 or below -16 sets status bit 4. Amounts from -16 to +16 have no effect.
- R7: Outputs are registered and respond one cycle after the faulting beat, so the operation completes first. A beat with `op_valid`=0 changes nothing.
- R8: Status bits are sticky until software writes 1 to the matching `sts_clr` bit. A cause detected in the same cycle as its clear leaves the bit set.
- R9: `trap_req` pulses for one cycle when a detected cause's bit is not already set, counting that bit as not set if it is being cleared in the same cycle. A cause repeating on a bit that is already set raises no trap.
- R10: After reset, `trap_req`, `div_abort` and all status bits are 0, and `op_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Completed-operation beat present |
| op_ready | output | 1 | Always 1; the block never stalls |
| op_acc_sel | input | 1 | Target accumulator: 0 = A, 1 = B |
| op_arith | input | 1 | Beat carries an accumulator result |
| op_result | input | 40 | Result before saturation |
| op_sign_x | input | 1 | Sign of first operand |
| op_sign_y | input | 1 | Sign of second operand |
| op_div | input | 1 | Divide start |
| op_divisor | input | 16 | Divisor |
| op_shift | input | 1 | Beat is a shift |
| op_shamt | input | 6 | Signed shift amount |
| cfg_ovf_a_en | input | 1 | Enable accumulator A bit-31 overflow trap |
| cfg_ovf_b_en | input | 1 | Enable accumulator B bit-31 overflow trap |
| cfg_cat_en | input | 1 | Enable catastrophic overflow trap |
| cfg_guard_used | input | 1 | Guard bits in use |
| cfg_sat_off | input | 1 | All saturation disabled |
| sts_clr | input | 5 | Write-1-to-clear for status bits |
| trap_req | output | 1 | One-cycle trap request |
| div_abort | output | 1 | Abort the running divide |
| sts_flags | output | 5 | Sticky cause flags |

## Verification
A divide by zero and an accumulator overflow can arrive in the same beat, because they come from different units. That beat must set both status bits, raise a single trap pulse and abort the divide. The bench provokes this directly with a zero divisor alongside a result that is mixed above bit 31. Its random phase sets the divide, arithmetic and shift flags independently, so such collisions also recur with clears pending. Each outcome is judged against a bench model of the flags, the trap and the abort.

// File: rtl/mtd_pkg.sv
package mtd_pkg;
  localparam int NCAUSE    = 5;
  localparam int CZ_OVF_A  = 0;
  localparam int CZ_OVF_B  = 1;
  localparam int CZ_CAT    = 2;
  localparam int CZ_DIVZ   = 3;
  localparam int CZ_SHIFT  = 4;
endpackage

// File: rtl/mtd_acc_check.sv
module mtd_acc_check #(
  parameter int ACC_W   = 40,
  parameter int OVF_BIT = 31,
  parameter int NUM_ACC = 2,
  localparam int SEL_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1,
  localparam int UP_W   = ACC_W - OVF_BIT
) (
  input  logic               beat,
  input  logic               arith,
  input  logic [SEL_W-1:0]   sel,
  input  logic [ACC_W-1:0]   result,
  input  logic               sign_x,
  input  logic               sign_y,
  input  logic [NUM_ACC-1:0] ovf_en,
  input  logic               guard_used,
  input  logic               cat_en,
  input  logic               sat_off,
  output logic [NUM_ACC-1:0] ovf_hit,
  output logic               cat_hit
);
  logic [UP_W-1:0] upper;
  logic            upper_mixed;
  logic            arith_beat;

  assign upper       = result[ACC_W-1:OVF_BIT];
  assign upper_mixed = !((&upper) || !(|upper));
  assign arith_beat  = beat && arith;

  for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
    assign ovf_hit[g] = arith_beat && (sel == SEL_W'(g)) && ovf_en[g]
                        && !guard_used && upper_mixed;
  end

  assign cat_hit = arith_beat && cat_en && sat_off && (sign_x == sign_y)
                   && (result[ACC_W-1] != sign_x);
endmodule

// File: rtl/mtd_unit_check.sv
module mtd_unit_check #(
  parameter int DIV_W  = 16,
  parameter int SH_W   = 6,
  parameter int SH_MAX = 16
) (
  input  logic             beat,
  input  logic             div_go,
  input  logic [DIV_W-1:0] divisor,
  input  logic             shift_go,
  input  logic [SH_W-1:0]  shamt,
  output logic             divz_hit,
  output logic             shift_hit
);
  logic signed [SH_W-1:0] amt_s;
  int                     amt_i;

  assign amt_s     = shamt;
  assign amt_i     = int'(amt_s);
  assign divz_hit  = beat && div_go && (divisor == '0);
  assign shift_hit = beat && shift_go && ((amt_i > SH_MAX) || (amt_i < -SH_MAX));
endmodule

// File: rtl/mtd_status.sv
module mtd_status #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags,
  output logic         trap
);
  logic [N-1:0] kept;
  logic [N-1:0] fresh;
  logic [N-1:0] flags_q;
  logic         trap_q;

  assign kept  = flags_q & ~clr;
  assign fresh = hit & ~kept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      trap_q  <= 1'b0;
    end else begin
      flags_q <= kept | hit;
      trap_q  <= |fresh;
    end
  end

  assign flags = flags_q;
  assign trap  = trap_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[i] && !clr[i]) |=> flags_q[i]); // R8
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[i] && clr[i] && !hit[i]) |=> !flags_q[i]); // R8
  end

  AST_TRAP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q |-> (|flags_q)); // R9
  AST_TRAP_REPEAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit & ~(flags_q & ~clr)) == '0) |=> !trap_q); // R9
endmodule

// File: rtl/math_trap_detector.sv
module math_trap_detector #(
  parameter int ACC_W   = 40,
  parameter int OVF_BIT = 31,
  parameter int DIV_W   = 16,
  parameter int SH_W    = 6,
  parameter int SH_MAX  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic             op_acc_sel,
  input  logic             op_arith,
  input  logic [ACC_W-1:0] op_result,
  input  logic             op_sign_x,
  input  logic             op_sign_y,
  input  logic             op_div,
  input  logic [DIV_W-1:0] op_divisor,
  input  logic             op_shift,
  input  logic [SH_W-1:0]  op_shamt,
  input  logic             cfg_ovf_a_en,
  input  logic             cfg_ovf_b_en,
  input  logic             cfg_cat_en,
  input  logic             cfg_guard_used,
  input  logic             cfg_sat_off,
  input  logic [4:0]       sts_clr,
  output logic             trap_req,
  output logic             div_abort,
  output logic [4:0]       sts_flags
);
  import mtd_pkg::*;

  logic [1:0]        ovf_hit;
  logic              cat_hit;
  logic              divz_hit;
  logic              shift_hit;
  logic [NCAUSE-1:0] hit;
  logic              abort_q;

  assign op_ready = 1'b1;

  mtd_acc_check #(.ACC_W(ACC_W), .OVF_BIT(OVF_BIT), .NUM_ACC(2)) u_acc (
    .beat(op_valid), .arith(op_arith), .sel(op_acc_sel), .result(op_result),
    .sign_x(op_sign_x), .sign_y(op_sign_y), .ovf_en({cfg_ovf_b_en, cfg_ovf_a_en}),
    .guard_used(cfg_guard_used), .cat_en(cfg_cat_en), .sat_off(cfg_sat_off),
    .ovf_hit(ovf_hit), .cat_hit(cat_hit)
  );

  mtd_unit_check #(.DIV_W(DIV_W), .SH_W(SH_W), .SH_MAX(SH_MAX)) u_unit (
    .beat(op_valid), .div_go(op_div), .divisor(op_divisor),
    .shift_go(op_shift), .shamt(op_shamt),
    .divz_hit(divz_hit), .shift_hit(shift_hit)
  );

  always_comb begin
    hit           = '0;
    hit[CZ_OVF_A] = ovf_hit[0];
    hit[CZ_OVF_B] = ovf_hit[1];
    hit[CZ_CAT]   = cat_hit;
    hit[CZ_DIVZ]  = divz_hit;
    hit[CZ_SHIFT] = shift_hit;
  end

  mtd_status #(.N(NCAUSE)) u_sts (
    .clk(clk), .rst_n(rst_n), .hit(hit), .clr(sts_clr),
    .flags(sts_flags), .trap(trap_req)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) abort_q <= 1'b0;
    else        abort_q <= divz_hit;
  end
  assign div_abort = abort_q;

  AST_DIVZ_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_div && (op_divisor == '0)) |=> (div_abort && sts_flags[CZ_DIVZ])); // R5
  AST_GUARD_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_guard_used && !sts_flags[CZ_OVF_A] && !sts_flags[CZ_OVF_B])
    |=> (!sts_flags[CZ_OVF_A] && !sts_flags[CZ_OVF_B])); // R3
  AST_SAT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_sat_off && !sts_flags[CZ_CAT]) |=> !sts_flags[CZ_CAT]); // R4
  AST_SHIFT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!(op_valid && op_shift) && !sts_flags[CZ_SHIFT]) |=> !sts_flags[CZ_SHIFT]); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!trap_req && !div_abort)); // R7
endmodule

// File: tb/sim_math_trap_detector.sv
module sim_math_trap_detector;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid, op_ready, op_acc_sel, op_arith, op_sign_x, op_sign_y;
  logic [39:0] op_result;
  logic op_div, op_shift;
  logic [15:0] op_divisor;
  logic [5:0] op_shamt;
  logic cfg_ovf_a_en, cfg_ovf_b_en, cfg_cat_en, cfg_guard_used, cfg_sat_off;
  logic [4:0] sts_clr;
  logic trap_req, div_abort;
  logic [4:0] sts_flags;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [4:0] exp_sts = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  math_trap_detector u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_acc_sel(op_acc_sel), .op_arith(op_arith), .op_result(op_result),
    .op_sign_x(op_sign_x), .op_sign_y(op_sign_y), .op_div(op_div),
    .op_divisor(op_divisor), .op_shift(op_shift), .op_shamt(op_shamt),
    .cfg_ovf_a_en(cfg_ovf_a_en), .cfg_ovf_b_en(cfg_ovf_b_en), .cfg_cat_en(cfg_cat_en),
    .cfg_guard_used(cfg_guard_used), .cfg_sat_off(cfg_sat_off), .sts_clr(sts_clr),
    .trap_req(trap_req), .div_abort(div_abort), .sts_flags(sts_flags)
  );

  function automatic logic [4:0] model_hits();
    logic [4:0] h = '0;
    logic mixed;
    int amt;
    if (!op_valid) return h;
    mixed = (op_result[39:31] != 9'h000) && (op_result[39:31] != 9'h1FF);
    if (op_arith) begin
      h[0] = !op_acc_sel && cfg_ovf_a_en && !cfg_guard_used && mixed;
      h[1] = op_acc_sel && cfg_ovf_b_en && !cfg_guard_used && mixed;
      h[2] = cfg_cat_en && cfg_sat_off && (op_sign_x == op_sign_y) && (op_result[39] != op_sign_x);
    end
    h[3] = op_div && (op_divisor == 16'd0);
    amt = op_shamt[5] ? int'(op_shamt) - 64 : int'(op_shamt);
    h[4] = op_shift && (amt > 16 || amt < -16);
    return h;
  endfunction

  task automatic idle();
    op_valid = 0; op_acc_sel = 0; op_arith = 0; op_result = '0;
    op_sign_x = 0; op_sign_y = 0; op_div = 0; op_divisor = 16'd1;
    op_shift = 0; op_shamt = '0; sts_clr = '0;
    cfg_ovf_a_en = 1; cfg_ovf_b_en = 1; cfg_cat_en = 1;
    cfg_guard_used = 0; cfg_sat_off = 1;
  endtask

  task automatic step(input string tag);
    logic [4:0] h, kept, fresh;
    logic exp_trap, exp_abort;
    h = model_hits();
    kept = exp_sts & ~sts_clr;
    fresh = h & ~kept;
    exp_trap = |fresh;
    exp_abort = h[3];
    exp_sts = kept | h;
    @(posedge clk); #1;
    checks++;
    if (sts_flags !== exp_sts || trap_req !== exp_trap || div_abort !== exp_abort) begin
      fails++;
      $display("FAIL %s: flags=%b trap=%b abort=%b expected flags=%b trap=%b abort=%b",
               tag, sts_flags, trap_req, div_abort, exp_sts, exp_trap, exp_abort);
    end
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7741));
    idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    checks++;
    if (sts_flags !== 5'b0 || trap_req !== 1'b0 || div_abort !== 1'b0 || op_ready !== 1'b1) begin
      fails++;
      $display("FAIL R10: flags=%b trap=%b abort=%b ready=%b expected 00000 0 0 1",
               sts_flags, trap_req, div_abort, op_ready);
    end

    // R1: accumulator A overflow out of bit 31
    op_valid = 1; op_arith = 1; op_result = 40'h00_8000_0000; step("R1");
    // R9: repeat on already-set bit, no trap
    op_valid = 1; op_arith = 1; op_result = 40'h00_8000_0000; step("R9");
    // R8: clear bit 0
    sts_clr = 5'b00001; step("R8");
    // R3: guard bits in use mask overflow
    op_valid = 1; op_arith = 1; op_acc_sel = 1; cfg_guard_used = 1; op_result = 40'h7F_0000_0000; step("R3");
    // R2: B overflow ignored when only A enabled
    op_valid = 1; op_arith = 1; op_acc_sel = 1; cfg_ovf_b_en = 0; op_result = 40'hFF_0000_0000; step("R2");
    // R2: B overflow with B enable
    op_valid = 1; op_arith = 1; op_acc_sel = 1; op_result = 40'hFF_0000_0000; step("R2");
    // R4: saturation on masks catastrophic overflow
    op_valid = 1; op_arith = 1; cfg_sat_off = 0; op_result = 40'h80_0000_0000; step("R4");
    // R4: catastrophic overflow
    op_valid = 1; op_arith = 1; op_result = 40'h80_0000_0000; step("R4");
    // R5: nonzero divisor, no effect
    op_valid = 1; op_div = 1; op_divisor = 16'd1; step("R5");
    // R5: divide by zero aborts
    op_valid = 1; op_div = 1; op_divisor = 16'd0; step("R5");
    // R5: abort is one cycle wide
    step("R5");
    // R6: +16 and -16 legal
    op_valid = 1; op_shift = 1; op_shamt = 6'd16; step("R6");
    op_valid = 1; op_shift = 1; op_shamt = 6'b110000; step("R6");
    // R6: -17 illegal
    op_valid = 1; op_shift = 1; op_shamt = 6'b101111; step("R6");
    // R7: beat not valid, error inputs ignored
    sts_clr = 5'b11111; step("R7");
    op_valid = 0; op_div = 1; op_divisor = 0; op_shift = 1; op_shamt = 6'd31;
    op_arith = 1; op_result = 40'h80_0000_0000; step("R7");
    // Same-cycle divide by zero and accumulator A overflow
    op_valid = 1; op_arith = 1; op_result = 40'h01_0000_0000; op_div = 1; op_divisor = 0; step("R5");
    // R8/R9: clear and re-detect in one cycle keeps bit, traps again
    op_valid = 1; op_div = 1; op_divisor = 0; sts_clr = 5'b01000; step("R8");
    // R6: +17 illegal
    op_valid = 1; op_shift = 1; op_shamt = 6'd17; step("R6");

    // Random phase (R7 general)
    for (int n = 0; n < 4000; n++) begin
      op_valid = ($urandom % 4) != 0;
      op_acc_sel = $urandom % 2;
      op_arith = $urandom % 2;
      if ($urandom % 2) op_result = {{9{$urandom % 2 == 1}}, 31'($urandom)};
      else op_result = {8'($urandom), 32'($urandom)};
      op_sign_x = $urandom % 2; op_sign_y = $urandom % 2;
      op_div = ($urandom % 3) == 0;
      op_divisor = ($urandom % 3 == 0) ? 16'd0 : 16'($urandom);
      op_shift = $urandom % 2;
      op_shamt = 6'($urandom);
      cfg_ovf_a_en = $urandom % 2; cfg_ovf_b_en = $urandom % 2;
      cfg_cat_en = $urandom % 2; cfg_guard_used = ($urandom % 4) == 0;
      cfg_sat_off = ($urandom % 4) != 0;
      sts_clr = ($urandom % 3 == 0) ? 5'($urandom) : 5'b0;
      step("R7");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule